// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port controlled through a single-cycle register bus. Software writes a data register and a direction register to drive pins. Input levels come in through a two-stage synchronizer, and software reads them back through the same data address.

Each pin has its own interrupt controls: a sense select for edge or level, a both-edge enable, an event polarity and a mask. Edge detections are held in per-pin latches, and software clears them by writing ones. In level mode the raw status follows the synchronized pin directly. The block presents the raw status, the masked status and the per-pin masked interrupt vector, and it ORs the masked vector into one interrupt line.

Top module: `gpio_irq_port`

## Requirements
- R1: Registers are word-aligned and decode exactly at these offsets: data 0x000, direction 0x400, sense 0x404, both-edge 0x408, event 0x40C, mask 0x410, raw status 0x414, masked status 0x418, clear 0x41C. A read returns data on `rdata_o` in the same cycle as `req_i`. Reads of any other address return 0.
- R2: `pin_oe_o` equals the direction register and `pin_o` equals the data register. A direction bit of 1 makes that pin an output.
- R3: A data read returns the written value on pins whose direction bit is 1. On the other pins it returns the synchronized input. A change on `pin_i` becomes visible two rising clock edges later.
- R4: When a pin's sense bit is 0 and its both-edge bit is 1, that pin latches both rising and falling edges, whatever its event bit holds.
- R5: When sense is 0 and both-edge is 0, an event bit of 1 latches rising edges only and an event bit of 0 latches falling edges only. The latch shows in raw status three rising edges after the pin changes.
- R6: A sense bit of 1 selects level mode. In this mode the raw bit is 1 exactly when the synchronized input equals the event bit. The bit is not latched, and the clear register does not affect it.
- R7: Writing 1 to a bit of the clear register clears that pin's edge latch, and a 0 bit leaves it alone. When a new edge and a clear land in the same cycle, the latch ends up set.
- R8: Masked status equals raw status AND mask. `irq_vec_o` carries the masked status, and `irq_o` is 1 exactly when any masked bit is 1.
- R9: Writes to the raw-status and masked-status addresses change no state. Reading the clear address returns 0.
- R10: After reset all registers and edge latches are 0. This makes every pin an input with no interrupt pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| pin_i | input | 32 | Asynchronous pin inputs |
| pin_o | output | 32 | Pin output values |
| pin_oe_o | output | 32 | Pin output enables |
| irq_vec_o | output | 32 | Per-pin masked interrupts |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench checks that one-way edge modes reject the opposite edge and that both-edge mode overrides the event bit. A design that decoded polarity wrongly would latch a falling edge on a rising-only pin, or would miss one direction in both-edge mode. It places a clear write on the exact clock edge where a new edge is latched. A design that let the clear win would lose that interrupt. In level mode it shows that a clear has no effect and that flipping the event bit changes the raw bit at once; a design that latched levels would keep a stale 1. It also writes to the status addresses and reads unmapped ones, which would expose a status register that software can write or a decoder that aliases addresses.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h400;
  localparam logic [ADDR_W-1:0] OFS_SENSE = 12'h404;
  localparam logic [ADDR_W-1:0] OFS_BOTH  = 12'h408;
  localparam logic [ADDR_W-1:0] OFS_EVENT = 12'h40C;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h410;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h414;
  localparam logic [ADDR_W-1:0] OFS_MSK   = 12'h418;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h41C;

  typedef enum logic [3:0] {
    SEL_DATA, SEL_DIR, SEL_SENSE, SEL_BOTH, SEL_EVENT,
    SEL_MASK, SEL_RAW, SEL_MSK, SEL_CLR, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_DATA:  return SEL_DATA;
      OFS_DIR:   return SEL_DIR;
      OFS_SENSE: return SEL_SENSE;
      OFS_BOTH:  return SEL_BOTH;
      OFS_EVENT: return SEL_EVENT;
      OFS_MASK:  return SEL_MASK;
      OFS_RAW:   return SEL_RAW;
      OFS_MSK:   return SEL_MSK;
      OFS_CLR:   return SEL_CLR;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      rdata_o,
  input  logic [N-1:0]      sync_i,
  input  logic [N-1:0]      raw_i,
  input  logic [N-1:0]      masked_i,
  output logic [N-1:0]      data_o,
  output logic [N-1:0]      dir_o,
  output logic [N-1:0]      sense_o,
  output logic [N-1:0]      both_o,
  output logic [N-1:0]      event_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      clr_o
);
  reg_sel_e sel;
  logic     wr;

  assign sel = decode_addr(addr_i);
  assign wr  = req_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      dir_o   <= '0;
      sense_o <= '0;
      both_o  <= '0;
      event_o <= '0;
      mask_o  <= '0;
    end else if (wr) begin
      case (sel)
        SEL_DATA:  data_o  <= wdata_i;
        SEL_DIR:   dir_o   <= wdata_i;
        SEL_SENSE: sense_o <= wdata_i;
        SEL_BOTH:  both_o  <= wdata_i;
        SEL_EVENT: event_o <= wdata_i;
        SEL_MASK:  mask_o  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_o = (wr && sel == SEL_CLR) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (sel)
        SEL_DATA:  rdata_o = (data_o & dir_o) | (sync_i & ~dir_o);
        SEL_DIR:   rdata_o = dir_o;
        SEL_SENSE: rdata_o = sense_o;
        SEL_BOTH:  rdata_o = both_o;
        SEL_EVENT: rdata_o = event_o;
        SEL_MASK:  rdata_o = mask_o;
        SEL_RAW:   rdata_o = raw_i;
        SEL_MSK:   rdata_o = masked_i;
        default:   rdata_o = '0;
      endcase
    end
  end

  // direction only moves on a direction write
  p_dir_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && sel == SEL_DIR) |=> $stable(dir_o));

  // status addresses are read-only
  p_status_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (sel == SEL_RAW || sel == SEL_MSK || sel == SEL_CLR))
      |=> $stable({data_o, dir_o, sense_o, both_o, event_o, mask_o}));
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] sense_i,
  input  logic [N-1:0] both_i,
  input  logic [N-1:0] event_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] raw_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] latch_q;
  logic [N-1:0] hit;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_pin
      logic rise, fall, sel_edge;
      assign rise     = sync_i[i] & ~prev_q[i];
      assign fall     = ~sync_i[i] & prev_q[i];
      assign sel_edge = both_i[i] ? (rise | fall) : (event_i[i] ? rise : fall);
      assign hit[i]   = ~sense_i[i] & sel_edge;
      assign raw_o[i] = sense_i[i] ? (sync_i[i] ~^ event_i[i]) : latch_q[i];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= sync_i;
      latch_q <= (latch_q & ~clr_i) | hit;  // a fresh edge beats a clear
    end
  end

  p_edge_latch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((latch_q & $past(hit)) == $past(hit)));

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((latch_q & $past(clr_i & ~hit)) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int N         = 32,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      rdata_o,
  input  logic [N-1:0]      pin_i,
  output logic [N-1:0]      pin_o,
  output logic [N-1:0]      pin_oe_o,
  output logic [N-1:0]      irq_vec_o,
  output logic              irq_o
);
  logic [N-1:0] sync, raw, sense, both, evt, mask, clr;

  gpio_sync #(.W(N), .STAGES(SYNC_STGS)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync)
  );

  gpio_regs #(.N(N)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .sync_i(sync), .raw_i(raw), .masked_i(irq_vec_o),
    .data_o(pin_o), .dir_o(pin_oe_o), .sense_o(sense), .both_o(both),
    .event_o(evt), .mask_o(mask), .clr_o(clr)
  );

  gpio_detect #(.N(N)) i_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync), .sense_i(sense),
    .both_i(both), .event_i(evt), .clr_i(clr), .raw_o(raw)
  );

  assign irq_vec_o = raw & mask;
  assign irq_o     = |irq_vec_o;

  p_irq_any_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((raw & mask) != '0));

  p_reset_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pin_oe_o == '0 && !irq_o));
endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, pin = '0;
  logic [31:0] rdata, pin_o, pin_oe, irq_vec;
  logic        irq;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .pin_o(pin_o),
    .pin_oe_o(pin_oe), .irq_vec_o(irq_vec), .irq_o(irq)
  );

  localparam logic [11:0] A_DATA = 12'h000, A_DIR = 12'h400, A_SENSE = 12'h404,
    A_BOTH = 12'h408, A_EVT = 12'h40C, A_MASK = 12'h410, A_RAW = 12'h414,
    A_MSK = 12'h418, A_CLR = 12'h41C;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard for every read seen on the bus
  always @(negedge clk) begin
    if (rst_n && req && !we) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    step(1);
    req = 0; we = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req = 1; we = 0; addr = a;
    step(1);
    req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R10 reset state
    check("R10 pin_oe reset", pin_oe, 0);
    check("R10 irq reset", {31'b0, irq}, 0);
    rd(A_DIR, 0, "R10 dir reset");
    rd(A_RAW, 0, "R10 raw reset");
    rd(A_DATA, 0, "R10 data reset");

    // R2 R3 data path
    wr(A_DIR, 32'h0000FFFF);
    wr(A_DATA, 32'hA5A51234);
    pin = 32'hDEADBEEF;
    step(2);
    rd(A_DATA, 32'hDEAD1234, "R3 mixed data read");
    check("R2 pin_o", pin_o, 32'hA5A51234);
    check("R2 pin_oe", pin_oe, 32'h0000FFFF);
    rd(A_DIR, 32'h0000FFFF, "R1 dir readback");
    wr(A_DIR, 0);
    rd(A_DATA, 32'hDEADBEEF, "R3 all-input read");
    pin = 0;
    step(3);
    wr(A_CLR, 32'hFFFFFFFF);
    rd(A_RAW, 0, "R7 clear all");

    // R5 rising on pin0, falling on pin1
    wr(A_EVT, 32'h1);
    pin = 32'h1; step(3);
    rd(A_RAW, 32'h1, "R5 rising latched");
    rd(A_MSK, 0, "R8 masked off");
    check("R8 irq masked", {31'b0, irq}, 0);
    wr(A_CLR, 32'h1);
    rd(A_RAW, 0, "R7 clear bit0");
    pin = 0; step(3);
    rd(A_RAW, 0, "R5 falling ignored on rising pin");
    pin = 32'h2; step(3);
    rd(A_RAW, 0, "R5 rising ignored on falling pin");
    pin = 0; step(3);
    rd(A_RAW, 32'h2, "R5 falling latched");

    // R4 both edges on pin2
    wr(A_BOTH, 32'h4);
    rd(A_BOTH, 32'h4, "R1 both readback");
    pin = 32'h4; step(3);
    rd(A_RAW, 32'h6, "R4 rise with both");
    wr(A_CLR, 32'h4);
    rd(A_RAW, 32'h2, "R7 clear bit2");
    pin = 0; step(3);
    rd(A_RAW, 32'h6, "R4 fall with both");
    wr(A_CLR, 0);
    rd(A_RAW, 32'h6, "R7 zero clear no effect");

    // R8 mask
    wr(A_MASK, 32'h4);
    rd(A_MSK, 32'h4, "R8 masked status");
    check("R8 irq asserted", {31'b0, irq}, 1);
    check("R8 irq vector", irq_vec, 32'h4);
    wr(A_CLR, 32'h4);
    rd(A_MSK, 0, "R8 masked cleared");
    check("R8 irq dropped", {31'b0, irq}, 0);

    // R9 read-only status, R1 unmapped
    wr(A_RAW, 32'hFFFFFFFF);
    wr(A_MSK, 32'hFFFFFFFF);
    rd(A_RAW, 32'h2, "R9 raw write ignored");
    rd(A_MASK, 32'h4, "R9 mask unchanged");
    rd(A_CLR, 0, "R9 clear reads zero");
    rd(12'h004, 0, "R1 unmapped reads zero");
    wr(A_CLR, 32'h2);
    rd(A_RAW, 0, "R7 clear bit1");

    // R6 level mode on pin3
    wr(A_SENSE, 32'h8);
    wr(A_EVT, 32'h9);
    rd(A_RAW, 0, "R6 high level absent");
    pin = 32'h8; step(2);
    rd(A_RAW, 32'h8, "R6 high level present");
    wr(A_CLR, 32'h8);
    rd(A_RAW, 32'h8, "R6 clear no effect");
    wr(A_EVT, 32'h1);
    rd(A_RAW, 0, "R6 polarity flip immediate");
    pin = 0; step(2);
    rd(A_RAW, 32'h8, "R6 low level present");
    wr(A_SENSE, 0);
    rd(A_RAW, 0, "R6 nothing latched in level mode");

    // R7 clear coincides with latching edge
    pin = 32'h1; step(2);
    wr(A_CLR, 32'h1);
    rd(A_RAW, 32'h1, "R7 edge wins over clear");
    wr(A_CLR, 32'h1);
    rd(A_RAW, 0, "R7 later clear");

    step(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule